// File: doc/BRIEF.md
# Raw Sensor Pixel Capture Front-End

This block sits between a camera analog front-end and a memory writer. Each clock it samples a 12-bit pixel bus together with a line-valid, a frame-valid and a field-identifier input. A pixel is taken only when both valid inputs are at their active level, after the programmable polarity has been applied. Taken pixels are packed into 16-bit words. Each word leaves on a plain address/data/valid write stream, with a byte address that follows the chosen field layout.

Eight-bit pixels are paired into one word. Wider pixels each occupy one zero-extended word, so every write is byte aligned. Top and bottom fields can go to two independent buffers, or they can share one frame buffer with alternating lines. Progressive sources drive a constant field identifier. The configuration inputs are copied into shadow registers only when the raw frame-valid input falls, so a frame in flight never sees a half-applied setting.

Top module: `raw_capture_frontend`

## Requirements
- R1: In 8-bit mode (mode code 0), pixel bits [7:0] are used. Each two consecutive pixels of a line form one write: the first pixel in data bits [7:0] and the second in bits [15:8].
- R2: In 10-bit mode (code 1), each pixel makes one write holding bus bits [9:0], with bits [15:10] zero. In 12-bit mode (code 2), and for the spare code 3, each write holds bus bits [11:0], with bits [15:12] zero.
- R3: In 8-bit mode, a line with an odd pixel count ends with one extra write. It carries the last pixel in bits [7:0] and zero in bits [15:8], and it appears in the cycle after the first inactive line-valid cycle.
- R4: A pixel is stored only when the effective line-valid and the effective frame-valid are both 1. Each effective level is the input XOR its invert bit (invert bit 0: high means active). Data in any blanking cycle produces no write.
- R5: The effective field is the field input XOR its invert bit. Effective 0 selects the top field and effective 1 the bottom field.
- R6: In separated layout (interleave bit 0), the address of a word is base + line*stride + 2*word index within the line. The base is the top base for the top field and the bottom base for the bottom field.
- R7: In interleaved layout (interleave bit 1), the address of a word is top base + (bottom field ? stride : 0) + line*2*stride + 2*word index.
- R8: The line count and word index restart on every rising edge of the effective frame-valid. The field is fixed by the effective field value sampled in that first cycle.
- R9: Mode, polarity, layout, bases and stride take effect only at a falling edge of the raw frame-valid input. Changes made at any other time do not alter writes.
- R10: After reset no write is issued. Each write is registered and appears one clock after the pixel cycle that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_hvalid | input | 1 | Line-valid from the front-end |
| in_vvalid | input | 1 | Frame-valid from the front-end; its raw falling edge loads the shadow settings |
| in_field | input | 1 | Field identifier |
| in_data | input | 12 | Raw pixel bus |
| cfg_pix_mode | input | 2 | Pixel width code: 0 = 8, 1 = 10, 2 or 3 = 12 bits |
| cfg_h_inv | input | 1 | Invert line-valid |
| cfg_v_inv | input | 1 | Invert frame-valid |
| cfg_f_inv | input | 1 | Invert field identifier |
| cfg_interleave | input | 1 | 1 = merged frame layout, 0 = separate field buffers |
| cfg_base_top | input | ADDR_W | Byte base of top field or frame buffer |
| cfg_base_bot | input | ADDR_W | Byte base of bottom field buffer |
| cfg_stride | input | ADDR_W | Bytes per stored line |
| wr_valid | output | 1 | Write strobe |
| wr_addr | output | ADDR_W | Byte address of the 16-bit word |
| wr_data | output | 16 | Packed pixel word |

## Verification
The bench runs whole fields: even line lengths in 8-bit mode (pairing only), odd line lengths (which separate pairing from the end-of-line flush), 10-bit, 12-bit and the spare code, and both layouts with top and bottom fields. One pass inverts all three polarities, so the valid gating and field selection are tried at both levels. During blanking, both horizontal and vertical, the bench drives live data and an asserted line-valid, so any leak shows up as an unexpected write. A settings change in the middle of a frame tells the shadow copy apart from a direct path: the frame in flight must keep the old base and width, and the next frame must use the new ones.

// File: rtl/rcap_pkg.sv
package rcap_pkg;

    localparam int RAW_W      = 12;
    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = WORD_W / BYTE_W;

    typedef enum logic [1:0] {
        PIX_8   = 2'd0,
        PIX_10  = 2'd1,
        PIX_12  = 2'd2,
        PIX_12X = 2'd3
    } pix_mode_e;

    typedef struct packed {
        pix_mode_e mode;
        logic      h_inv;
        logic      v_inv;
        logic      f_inv;
        logic      interleave;
    } cap_cfg_t;

    typedef struct packed {
        logic act;     // pixel in active area this cycle
        logic fstart;  // first cycle of an active field
        logic lend;    // first inactive cycle after an active run
        logic field;   // effective field identifier
    } sync_evt_t;

    function automatic logic [WORD_W-1:0] widen_pixel(pix_mode_e m, logic [RAW_W-1:0] d);
        case (m)
            PIX_10:  return {{(WORD_W-10){1'b0}}, d[9:0]};
            default: return {{(WORD_W-RAW_W){1'b0}}, d};
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pair_bytes(logic [BYTE_W-1:0] lo, logic [BYTE_W-1:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/rc_shadow_cfg.sv
module rc_shadow_cfg
    import rcap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           raw_v,
    input  cap_cfg_t       cfg_in,
    input  logic [AW-1:0]  btop_in,
    input  logic [AW-1:0]  bbot_in,
    input  logic [AW-1:0]  stride_in,
    output cap_cfg_t       cfg_q,
    output logic [AW-1:0]  btop_q,
    output logic [AW-1:0]  bbot_q,
    output logic [AW-1:0]  stride_q
);
    logic raw_v_prev;
    logic load;

    assign load = raw_v_prev & ~raw_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_v_prev <= 1'b0;
            cfg_q      <= '0;
            btop_q     <= '0;
            bbot_q     <= '0;
            stride_q   <= '0;
        end else begin
            raw_v_prev <= raw_v;
            if (load) begin
                cfg_q    <= cfg_in;
                btop_q   <= btop_in;
                bbot_q   <= bbot_in;
                stride_q <= stride_in;
            end
        end
    end
endmodule

// File: rtl/rc_sync_qual.sv
module rc_sync_qual
    import rcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hv,
    input  logic      vv,
    input  logic      fv,
    input  cap_cfg_t  cfg,
    output sync_evt_t evt
);
    logic h_eff, v_eff, f_eff, act;
    logic v_prev, act_prev;

    assign h_eff = hv ^ cfg.h_inv;
    assign v_eff = vv ^ cfg.v_inv;
    assign f_eff = fv ^ cfg.f_inv;
    assign act   = h_eff & v_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_prev   <= 1'b0;
            act_prev <= 1'b0;
        end else begin
            v_prev   <= v_eff;
            act_prev <= act;
        end
    end

    always_comb begin
        evt.act    = act;
        evt.fstart = v_eff & ~v_prev;
        evt.lend   = act_prev & ~act;
        evt.field  = f_eff;
    end
endmodule

// File: rtl/rc_addr_gen.sv
module rc_addr_gen
    import rcap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  sync_evt_t     evt,
    input  logic          adv,
    input  logic          interleave,
    input  logic [AW-1:0] btop,
    input  logic [AW-1:0] bbot,
    input  logic [AW-1:0] stride,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] line_base_q, col_q;
    logic [AW-1:0] line_base_c, col_c;
    logic [AW-1:0] pitch, start_base, start_off;

    assign pitch      = interleave ? (stride << 1) : stride;
    assign start_base = (evt.field & ~interleave) ? bbot : btop;
    assign start_off  = (evt.field & interleave) ? stride : '0;

    assign line_base_c = evt.fstart ? (start_base + start_off) : line_base_q;
    assign col_c       = evt.fstart ? '0 : col_q;
    assign addr        = line_base_c + col_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_base_q <= '0;
            col_q       <= '0;
        end else if (evt.lend) begin
            line_base_q <= line_base_c + pitch;
            col_q       <= '0;
        end else begin
            line_base_q <= line_base_c;
            col_q       <= adv ? (col_c + STEP) : col_c;
        end
    end
endmodule

// File: rtl/rc_packer.sv
module rc_packer
    import rcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sync_evt_t         evt,
    input  pix_mode_e         mode,
    input  logic [RAW_W-1:0]  din,
    output logic              emit,
    output logic [WORD_W-1:0] word
);
    logic              pend_q;
    logic [BYTE_W-1:0] hold_q;
    logic              narrow;

    assign narrow = (mode == PIX_8);

    always_comb begin
        emit = 1'b0;
        word = '0;
        if (narrow) begin
            if (evt.act && pend_q) begin
                emit = 1'b1;
                word = pair_bytes(hold_q, din[BYTE_W-1:0]);
            end else if (evt.lend && pend_q) begin
                emit = 1'b1;
                word = pair_bytes(hold_q, '0);
            end
        end else if (evt.act) begin
            emit = 1'b1;
            word = widen_pixel(mode, din);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            hold_q <= '0;
        end else if (!narrow || evt.lend) begin
            pend_q <= 1'b0;
        end else if (evt.act) begin
            pend_q <= ~pend_q;
            if (!pend_q) hold_q <= din[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/raw_capture_frontend.sv
module raw_capture_frontend
    import rcap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_hvalid,
    input  logic              in_vvalid,
    input  logic              in_field,
    input  logic [11:0]       in_data,
    input  logic [1:0]        cfg_pix_mode,
    input  logic              cfg_h_inv,
    input  logic              cfg_v_inv,
    input  logic              cfg_f_inv,
    input  logic              cfg_interleave,
    input  logic [ADDR_W-1:0] cfg_base_top,
    input  logic [ADDR_W-1:0] cfg_base_bot,
    input  logic [ADDR_W-1:0] cfg_stride,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data
);
    cap_cfg_t          cfg_in, sh_cfg;
    logic [ADDR_W-1:0] sh_btop, sh_bbot, sh_stride;
    sync_evt_t         evt;
    logic              q_act, q_lend;
    logic              emit;
    logic [WORD_W-1:0] word;
    logic [ADDR_W-1:0] addr;

    always_comb begin
        cfg_in.mode       = pix_mode_e'(cfg_pix_mode);
        cfg_in.h_inv      = cfg_h_inv;
        cfg_in.v_inv      = cfg_v_inv;
        cfg_in.f_inv      = cfg_f_inv;
        cfg_in.interleave = cfg_interleave;
    end

    rc_shadow_cfg #(.AW(ADDR_W)) u_shadow (
        .clk(clk), .rst(rst), .raw_v(in_vvalid),
        .cfg_in(cfg_in), .btop_in(cfg_base_top), .bbot_in(cfg_base_bot), .stride_in(cfg_stride),
        .cfg_q(sh_cfg), .btop_q(sh_btop), .bbot_q(sh_bbot), .stride_q(sh_stride)
    );

    rc_sync_qual u_sync (
        .clk(clk), .rst(rst), .hv(in_hvalid), .vv(in_vvalid), .fv(in_field),
        .cfg(sh_cfg), .evt(evt)
    );

    assign q_act  = evt.act;
    assign q_lend = evt.lend;

    rc_packer u_pack (
        .clk(clk), .rst(rst), .evt(evt), .mode(sh_cfg.mode), .din(in_data),
        .emit(emit), .word(word)
    );

    rc_addr_gen #(.AW(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .evt(evt), .adv(emit), .interleave(sh_cfg.interleave),
        .btop(sh_btop), .bbot(sh_bbot), .stride(sh_stride), .addr(addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= emit;
            if (emit) begin
                wr_addr <= addr;
                wr_data <= word;
            end
        end
    end
endmodule

// File: rtl/rc_capture_chk.sv
module rc_capture_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_vvalid,
    input logic          wr_valid,
    input logic [15:0]   wr_data,
    input logic          act,
    input logic          lend,
    input logic [1:0]    sh_mode,
    input logic [AW-1:0] sh_btop,
    input logic [AW-1:0] sh_stride
);
    // R4: a write only follows an active pixel or a line-end flush
    assert_blank_drop_R4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(act || lend));

    // R2: 12-bit words keep the top nibble clear
    assert_zero_ext12_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && $past(sh_mode) == 2'd2) |-> (wr_data[15:12] == 4'h0));

    // R2: 10-bit words keep the top six bits clear
    assert_zero_ext10_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && $past(sh_mode) == 2'd1) |-> (wr_data[15:10] == 6'h0));

    // R1: in 8-bit mode no two writes are back to back
    assert_pair_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && $past(wr_valid)) |-> !($past(sh_mode, 1) == 2'd0 && $past(sh_mode, 2) == 2'd0));

    // R9: shadow settings move only after a raw frame-valid fall
    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$fell(in_vvalid) |=> ($stable(sh_btop) && $stable(sh_stride) && $stable(sh_mode)));
endmodule

bind raw_capture_frontend rc_capture_chk #(.AW(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .in_vvalid(in_vvalid), .wr_valid(wr_valid), .wr_data(wr_data),
    .act(q_act), .lend(q_lend), .sh_mode(sh_cfg.mode), .sh_btop(sh_btop), .sh_stride(sh_stride)
);

// File: tb/test_raw_capture_frontend.sv
module test_raw_capture_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_hvalid = 1'b0, in_vvalid = 1'b0, in_field = 1'b0;
    logic [11:0] in_data = '0;
    logic [1:0] cfg_pix_mode = '0;
    logic cfg_h_inv = 1'b0, cfg_v_inv = 1'b0, cfg_f_inv = 1'b0, cfg_interleave = 1'b0;
    logic [AW-1:0] cfg_base_top = '0, cfg_base_bot = '0, cfg_stride = '0;
    logic wr_valid;
    logic [AW-1:0] wr_addr;
    logic [15:0] wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    raw_capture_frontend #(.ADDR_W(AW)) i_raw_capture_frontend (
        .clk(clk), .rst(rst), .in_hvalid(in_hvalid), .in_vvalid(in_vvalid), .in_field(in_field),
        .in_data(in_data), .cfg_pix_mode(cfg_pix_mode), .cfg_h_inv(cfg_h_inv), .cfg_v_inv(cfg_v_inv),
        .cfg_f_inv(cfg_f_inv), .cfg_interleave(cfg_interleave), .cfg_base_top(cfg_base_top),
        .cfg_base_bot(cfg_base_bot), .cfg_stride(cfg_stride),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic [15:0]   data;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // settings the design is expected to be using
    int m_mode;
    bit m_hinv, m_vinv, m_finv, m_il;
    logic [AW-1:0] m_btop, m_bbot, m_stride;
    int junk = 17;

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && wr_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R4 unexpected write: actual addr=%h data=%h, expected none", wr_addr, wr_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (wr_addr !== e.addr || wr_data !== e.data) begin
                    n_bad++;
                    $display("FAIL %s: actual addr=%h data=%h, expected addr=%h data=%h",
                             e.tag, wr_addr, wr_data, e.addr, e.data);
                end
            end
        end
    end

    task automatic drive(input bit h, input bit v, input bit f, input logic [11:0] d);
        in_hvalid = h; in_vvalid = v; in_field = f; in_data = d;
        @(negedge clk);
    endtask

    function automatic logic [11:0] noise();
        junk = (junk * 29 + 11) % 4093;
        return 12'(junk);
    endfunction

    task automatic adopt_ports();
        m_mode = int'(cfg_pix_mode); m_hinv = cfg_h_inv; m_vinv = cfg_v_inv; m_finv = cfg_f_inv;
        m_il = cfg_interleave; m_btop = cfg_base_top; m_bbot = cfg_base_bot; m_stride = cfg_stride;
    endtask

    // R9: settings enter through a raw frame-valid fall
    task automatic load_cfg(input int mode, input bit hinv, input bit vinv, input bit finv, input bit il,
                            input logic [AW-1:0] bt, input logic [AW-1:0] bb, input logic [AW-1:0] st);
        cfg_pix_mode = 2'(mode); cfg_h_inv = hinv; cfg_v_inv = vinv; cfg_f_inv = finv;
        cfg_interleave = il; cfg_base_top = bt; cfg_base_bot = bb; cfg_stride = st;
        drive(m_hinv, 1'b1, 1'b0, noise());
        drive(m_hinv, 1'b1, 1'b0, noise());
        drive(m_hinv, 1'b0, 1'b0, noise());
        adopt_ports();
        drive(m_hinv, m_vinv, 1'b0, noise());
        drive(m_hinv, m_vinv, 1'b0, noise());
    endtask

    task automatic push_exp(input logic [AW-1:0] a, input logic [15:0] d, input string t);
        exp_t e;
        e.addr = a; e.data = d; e.tag = t;
        exp_q.push_back(e);
    endtask

    task automatic frame(input bit fld, input int nl, input int np, input int seed,
                         input bit chg, input string ftag);
        logic [AW-1:0] fb, pitch, lb;
        logic [7:0] held;
        bit fraw, hon, hoff, von, voff;
        string ltag;
        hon = ~m_hinv; hoff = m_hinv; von = ~m_vinv; voff = m_vinv; fraw = fld ^ m_finv;
        // R8/R5/R6/R7: field base chosen at field start
        fb    = (m_il || !fld) ? m_btop : m_bbot;
        if (m_il && fld) fb = fb + m_stride;
        pitch = m_il ? (m_stride << 1) : m_stride;
        ltag  = m_il ? "R7" : "R6";
        held  = '0;
        drive(hoff, von, fraw, noise());
        drive(hoff, von, fraw, noise());
        for (int l = 0; l < nl; l++) begin
            lb = fb + AW'(l) * pitch;
            for (int p = 0; p < np; p++) begin
                logic [11:0] d;
                d = 12'((seed * 97 + l * 41 + p * 13 + 5) % 4096);
                if (m_mode == 0) begin
                    if (p % 2 == 0) held = d[7:0];
                    else push_exp(lb + AW'((p / 2) * 2), {d[7:0], held}, {"R1/", ltag, "/", ftag});
                end else if (m_mode == 1) begin
                    push_exp(lb + AW'(p * 2), {6'h0, d[9:0]}, {"R2/", ltag, "/", ftag});
                end else begin
                    push_exp(lb + AW'(p * 2), {4'h0, d}, {"R2/", ltag, "/", ftag});
                end
                drive(hon, von, fraw, d);
            end
            if (m_mode == 0 && (np % 2) == 1)
                push_exp(lb + AW'((np / 2) * 2), {8'h00, held}, {"R3/", ltag, "/", ftag});
            if (chg && l == 0) begin
                // R9: new settings presented mid-frame must not apply yet
                cfg_base_top = cfg_base_top + 32'h0000_0100;
                cfg_pix_mode = 2'd1;
            end
            drive(hoff, von, fraw, noise());
            drive(hoff, von, fraw, noise());
        end
        // R4: horizontal valid during vertical blanking must be dropped
        drive(hoff, voff, fraw, noise());
        drive(hon, voff, fraw, noise());
        drive(hon, voff, fraw, noise());
        drive(hoff, voff, fraw, noise());
        if (!m_vinv) adopt_ports();
        drive(hoff, voff, fraw, noise());
    endtask

    initial begin
        adopt_ports();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: quiet after reset
        n_cmp++;
        if (wr_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: actual wr_valid=%b expected 0", wr_valid);
        end

        load_cfg(0, 0, 0, 0, 0, 32'h0000_1000, 32'h0000_8000, 32'h0000_0040);
        frame(1'b0, 3, 6, 1, 1'b0, "R8");
        frame(1'b1, 2, 5, 2, 1'b0, "R6");
        frame(1'b0, 2, 4, 3, 1'b0, "R8");

        load_cfg(1, 0, 0, 0, 1, 32'h0000_2000, 32'h0000_9000, 32'h0000_0020);
        frame(1'b0, 2, 4, 4, 1'b0, "R7");
        frame(1'b1, 2, 4, 5, 1'b0, "R7");

        load_cfg(2, 1, 1, 1, 0, 32'h0000_3000, 32'h0000_5000, 32'h0000_0030);
        frame(1'b1, 2, 3, 6, 1'b0, "R5");
        frame(1'b0, 1, 3, 7, 1'b0, "R4");

        load_cfg(3, 0, 0, 0, 0, 32'h0000_4000, 32'h0000_6000, 32'h0000_0010);
        frame(1'b0, 1, 3, 8, 1'b0, "R2");

        load_cfg(0, 0, 0, 0, 0, 32'h0000_7000, 32'h0000_A000, 32'h0000_0080);
        frame(1'b0, 2, 4, 9, 1'b1, "R9");
        frame(1'b0, 1, 4, 10, 1'b0, "R9");

        repeat (4) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s missing writes: actual pending=%0d expected 0", exp_q[0].tag, exp_q.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog: actual hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule